// File: doc/BRIEF.md
# Reconfigurable Block Handshake Shell

This shell wraps a hardware block that is loaded into a reconfigurable region at run time. It has two sides. The reconfiguration side asks for the block to be loaded and then switches it on. The application side hands data to the block and collects the results. The shell turns both exchanges into one ordered sequence. A load request stays up until the loader confirms the block is present. A present-flag then waits for the enable. Only after the enable does the block report that it is ready for use.

While the block is ready, an application cycle runs in three steps. The application raises a data-ready level, and the shell gives the compute core a one-cycle start pulse. When the core reports it has finished, the shell raises an execution-done flag and sends the core a one-cycle acknowledge. The application polls that flag, takes the results and acknowledges them. The shell then clears the flag and waits for the next data-ready. Dropping the enable after the block has been switched on returns the whole shell to idle, and a new load request is then needed.

All outputs come straight from registers. Each input change shows at the outputs one clock later.

Top module: `rblk_shell`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, load_req, present, ready, core_start, core_ack and exec_done are all 0.
- R2: A high load_start sampled while the shell is idle makes load_req 1 from the next cycle. load_req stays 1 until a high load_ack is sampled, and is 0 from the cycle after that.
- R3: A high load_ack sampled while load_req is 1 makes present 1 from the next cycle. present stays 1 until the enable is withdrawn after the block has become ready.
- R4: A high enable sampled while present is 1 and ready is 0 makes ready 1 from the next cycle.
- R5: While the shell is idle or loading, enable and load_ack have no effect on present or ready, except the load_ack that ends loading as in R2.
- R6: A high data_rdy sampled while ready is 1 and no job is running or finished produces a core_start pulse exactly one cycle long, starting the next cycle.
- R7: A high core_done sampled while a job is running makes exec_done 1 from the next cycle and produces a core_ack pulse exactly one cycle long in that same cycle.
- R8: A high data_ack sampled while exec_done is 1 makes exec_done 0 from the next cycle. The shell then waits for data_rdy again.
- R9: These inputs have no effect on the outputs: data_rdy while ready is 0, core_done when no job is running, and data_ack while exec_done is 0.
- R10: A low enable sampled while ready is 1 makes ready, present, exec_done, core_start and core_ack all 0 from the next cycle. The shell is then idle and needs load_start again.
- R11: core_start and core_ack are never 1 together, and load_req and ready are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_start | input | 1 | Reconfiguration side asks for the block to be loaded |
| load_req | output | 1 | Load request to the configuration loader |
| load_ack | input | 1 | Loader reports the block is present in the region |
| present | output | 1 | Block is loaded and waiting for enable, or is enabled |
| enable | input | 1 | Reconfiguration side switches the block on; low switches it off |
| ready | output | 1 | Block is ready for use by the application side |
| data_rdy | input | 1 | Application side has input data prepared |
| exec_done | output | 1 | Results are readable |
| data_ack | input | 1 | Application side has taken the results |
| core_start | output | 1 | One-cycle start pulse to the compute core |
| core_done | input | 1 | Compute core has finished its job |
| core_ack | output | 1 | One-cycle acknowledge to the compute core |

## Verification
The hardest case to reach from the ports is the enable being withdrawn while a job is in flight inside the core. The core's late completion must then be dropped, and the stale state must not come back after the block is reloaded. The stimulus starts a job with a long core latency and drops enable one cycle after the start pulse. It then lets the stub core finish while the shell is idle, and runs a full reload followed by a new job. Two other cases are set up early: data-ready held high from before the block is loaded, and load or enable pulses given while the shell is idle.

// File: rtl/rblk_pkg.sv
package rblk_pkg;

    typedef enum logic [1:0] {
        CFG_IDLE   = 2'd0,
        CFG_LOAD   = 2'd1,
        CFG_WAITEN = 2'd2,
        CFG_ACTIVE = 2'd3
    } cfg_state_e;

    typedef enum logic [1:0] {
        APP_WAIT = 2'd0,
        APP_RUN  = 2'd1,
        APP_DONE = 2'd2
    } app_state_e;

    typedef struct packed {
        cfg_state_e state;
        logic       load_req;
        logic       present;
        logic       ready;
    } cfg_regs_t;

    typedef struct packed {
        app_state_e state;
        logic       core_start;
        logic       core_ack;
        logic       exec_done;
    } app_regs_t;

endpackage

// File: rtl/rblk_cfg_seq.sv
module rblk_cfg_seq
    import rblk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_start,
    input  logic load_ack,
    input  logic enable,
    output logic load_req,
    output logic present,
    output logic ready
);

    cfg_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            CFG_IDLE: begin
                if (load_start) begin
                    r_d.state    = CFG_LOAD;
                    r_d.load_req = 1'b1;
                end
            end
            CFG_LOAD: begin
                if (load_ack) begin
                    r_d.state    = CFG_WAITEN;
                    r_d.load_req = 1'b0;
                    r_d.present  = 1'b1;
                end
            end
            CFG_WAITEN: begin
                if (enable) begin
                    r_d.state = CFG_ACTIVE;
                    r_d.ready = 1'b1;
                end
            end
            CFG_ACTIVE: begin
                if (!enable) begin
                    r_d.state    = CFG_IDLE;
                    r_d.load_req = 1'b0;
                    r_d.present  = 1'b0;
                    r_d.ready    = 1'b0;
                end
            end
            default: begin
                r_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign load_req = r_q.load_req;
    assign present  = r_q.present;
    assign ready    = r_q.ready;

endmodule

// File: rtl/rblk_app_seq.sv
module rblk_app_seq
    import rblk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic blk_ready,
    input  logic data_rdy,
    input  logic core_done,
    input  logic data_ack,
    output logic core_start,
    output logic core_ack,
    output logic exec_done
);

    app_regs_t r_d, r_q;

    always_comb begin
        r_d            = r_q;
        r_d.core_start = 1'b0;
        r_d.core_ack   = 1'b0;
        if (!enable || !blk_ready) begin
            r_d = '0;
        end else begin
            unique case (r_q.state)
                APP_WAIT: begin
                    if (data_rdy) begin
                        r_d.state      = APP_RUN;
                        r_d.core_start = 1'b1;
                    end
                end
                APP_RUN: begin
                    if (core_done) begin
                        r_d.state     = APP_DONE;
                        r_d.core_ack  = 1'b1;
                        r_d.exec_done = 1'b1;
                    end
                end
                APP_DONE: begin
                    if (data_ack) begin
                        r_d.state     = APP_WAIT;
                        r_d.exec_done = 1'b0;
                    end
                end
                default: begin
                    r_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_start = r_q.core_start;
    assign core_ack   = r_q.core_ack;
    assign exec_done  = r_q.exec_done;

endmodule

// File: rtl/rblk_shell.sv
module rblk_shell (
    input  logic clk,
    input  logic rst_n,
    input  logic load_start,
    output logic load_req,
    input  logic load_ack,
    output logic present,
    input  logic enable,
    output logic ready,
    input  logic data_rdy,
    output logic exec_done,
    input  logic data_ack,
    output logic core_start,
    input  logic core_done,
    output logic core_ack
);

    logic blk_ready;

    rblk_cfg_seq u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .load_ack   (load_ack),
        .enable     (enable),
        .load_req   (load_req),
        .present    (present),
        .ready      (blk_ready)
    );

    rblk_app_seq u_app (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .blk_ready  (blk_ready),
        .data_rdy   (data_rdy),
        .core_done  (core_done),
        .data_ack   (data_ack),
        .core_start (core_start),
        .core_ack   (core_ack),
        .exec_done  (exec_done)
    );

    assign ready = blk_ready;

endmodule

// File: rtl/rblk_shell_chk.sv
module rblk_shell_chk (
    input logic clk,
    input logic rst_n,
    input logic load_start,
    input logic load_req,
    input logic load_ack,
    input logic present,
    input logic enable,
    input logic ready,
    input logic data_rdy,
    input logic exec_done,
    input logic data_ack,
    input logic core_start,
    input logic core_done,
    input logic core_ack
);

    AST_LOADREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load_req && !load_ack |=> load_req); // R2

    AST_LOAD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        load_req && load_ack |=> present && !load_req); // R3

    AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(enable) && $past(present)); // R4

    AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !load_req && !present && !ready |=> !ready && !present); // R5

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R6

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_start) |-> $past(data_rdy) && $past(ready)); // R9

    AST_ACK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |-> exec_done); // R7

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done && data_ack && enable |=> !exec_done); // R8

    AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !enable |=> !ready && !present && !exec_done && !core_start && !core_ack); // R10

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_start && core_ack) && !(load_req && ready)); // R11

endmodule

bind rblk_shell rblk_shell_chk u_chk (.*);

// File: tb/rblk_shell_test.sv
`timescale 1ns/100ps
module rblk_shell_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_start = 1'b0, load_ack = 1'b0, enable = 1'b0;
    logic data_rdy = 1'b0, data_ack = 1'b0, stray_done = 1'b0, stub_done = 1'b0;
    logic load_req, present, ready, exec_done, core_start, core_ack, core_done;

    integer checks = 0;
    integer errors = 0;
    integer starts_seen = 0;
    integer acc = 0;
    integer lat = 2;
    integer cnt = 0;

    // reference model state
    integer cph = 0;
    integer aph = 0;
    logic e_lreq = 0, e_pres = 0, e_rdy = 0, e_start = 0, e_ack = 0, e_done = 0;
    logic model_on = 0;

    always #2.5 clk = ~clk;

    assign core_done = stub_done | stray_done;

    rblk_shell uut (
        .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_req(load_req),
        .load_ack(load_ack), .present(present), .enable(enable), .ready(ready),
        .data_rdy(data_rdy), .exec_done(exec_done), .data_ack(data_ack),
        .core_start(core_start), .core_done(core_done), .core_ack(core_ack)
    );

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        logic old_rdy;
        if (!rst_n) begin
            cph = 0; aph = 0;
            e_lreq = 0; e_pres = 0; e_rdy = 0; e_start = 0; e_ack = 0; e_done = 0;
        end else begin
            old_rdy = e_rdy;
            e_start = 0;
            e_ack = 0;
            if (cph == 0 && load_start) cph = 1;
            else if (cph == 1 && load_ack) cph = 2;
            else if (cph == 2 && enable) cph = 3;
            else if (cph == 3 && !enable) cph = 0;
            if (!enable || !old_rdy) begin
                aph = 0;
            end else if (aph == 0 && data_rdy) begin
                aph = 1; e_start = 1;
            end else if (aph == 1 && core_done) begin
                aph = 2; e_ack = 1;
            end else if (aph == 2 && data_ack) begin
                aph = 0;
            end
            e_lreq = (cph == 1);
            e_pres = (cph >= 2);
            e_rdy  = (cph == 3);
            e_done = (aph == 2);
        end
    end

    // per-cycle comparison away from the rising edge
    always @(negedge clk) begin
        if (model_on) begin
            check("R2", "load_req", load_req, e_lreq);
            check("R3", "present", present, e_pres);
            check("R4", "ready", ready, e_rdy);
            check("R6", "core_start", core_start, e_start);
            check("R7", "core_ack", core_ack, e_ack);
            check("R8", "exec_done", exec_done, e_done);
        end
    end

    // compute core stub: accumulator with programmable latency
    always @(negedge clk) begin
        stub_done <= 1'b0;
        if (core_start) begin
            starts_seen = starts_seen + 1;
            acc = acc + starts_seen;
            cnt = lat;
        end else if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) stub_done <= 1'b1;
        end
    end

    initial begin
        #(5 * 20000);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_up();
    end

    task automatic cyc(input integer n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_and_enable;
        load_start = 1; cyc(1); load_start = 0;
        cyc(2);
        load_ack = 1; cyc(1); load_ack = 0;
        enable = 1;
        while (!ready) cyc(1);
    endtask

    task automatic run_job(input integer latency, input integer ack_delay);
        lat = latency;
        data_rdy = 1; cyc(1); data_rdy = 0;
        while (!exec_done) cyc(1);
        cyc(ack_delay);
        data_ack = 1; cyc(1); data_ack = 0;
        cyc(1);
        check("R8", "exec_done after data_ack", exec_done, 1'b0);
    endtask

    initial begin
        cyc(1);
        check("R1", "load_req in reset", load_req, 1'b0);
        check("R1", "ready in reset", ready, 1'b0);
        cyc(3);
        rst_n = 1;
        cyc(1);
        model_on = 1;
        check("R1", "present after reset", present, 1'b0);
        check("R1", "exec_done after reset", exec_done, 1'b0);

        // R5: enable and load_ack while idle have no effect
        enable = 1; load_ack = 1; cyc(3);
        check("R5", "present while idle", present, 1'b0);
        check("R5", "ready while idle", ready, 1'b0);
        load_ack = 0; enable = 0;

        // R9: data_rdy held high from before the block is ready
        data_rdy = 1;
        load_start = 1; cyc(1); load_start = 0;
        enable = 1; cyc(2);
        check("R2", "load_req held", load_req, 1'b1);
        check("R5", "ready during load", ready, 1'b0);
        check("R9", "no start before ready", core_start, 1'b0);
        enable = 0;
        load_ack = 1; cyc(1); load_ack = 0;
        cyc(2);
        check("R3", "present waiting enable", present, 1'b1);
        check("R4", "ready waiting enable", ready, 1'b0);
        enable = 1; cyc(1);
        check("R4", "ready after enable", ready, 1'b1);
        check("R9", "no start on ready rise", core_start, 1'b0);
        cyc(1);
        check("R6", "start after ready", core_start, 1'b1);
        data_rdy = 0;
        cyc(1);
        check("R6", "start is one cycle", core_start, 1'b0);
        data_ack = 1; cyc(1); data_ack = 0;   // R9: early data_ack ignored
        while (!exec_done) cyc(1);
        check("R9", "stray data_ack ignored", exec_done, 1'b1);
        data_ack = 1; cyc(1); data_ack = 0;

        // several jobs with different core latencies and ack delays
        run_job(1, 0);
        run_job(3, 2);
        run_job(7, 5);

        // R9: core_done with no job running is ignored
        stray_done = 1; cyc(2); stray_done = 0;
        cyc(1);
        check("R9", "stray core_done ignored", exec_done, 1'b0);

        // R10: enable withdrawn with a job in flight
        lat = 9;
        data_rdy = 1; cyc(1); data_rdy = 0;
        cyc(1);
        enable = 0; cyc(1);
        check("R10", "ready cleared", ready, 1'b0);
        check("R10", "present cleared", present, 1'b0);
        cyc(12);
        check("R10", "late core_done ignored", exec_done, 1'b0);
        enable = 1; cyc(3);
        check("R10", "enable alone does not reload", ready, 1'b0);
        enable = 0;
        load_and_enable();
        run_job(2, 1);

        // R10: enable withdrawn while results are pending
        lat = 2;
        data_rdy = 1; cyc(1); data_rdy = 0;
        while (!exec_done) cyc(1);
        enable = 0; cyc(1);
        check("R10", "exec_done cleared", exec_done, 1'b0);
        cyc(2);
        check("R11", "load_req and ready exclusive", load_req & ready, 1'b0);

        check("R6", "core stub start count", (starts_seen == 7 && acc == 28), 1'b1);
        model_on = 0;
        finish_up();
    end

endmodule